// File: doc/BRIEF.md
# ASID-Tagged Address Translation Cache

This block is a small fully associative cache of page translations. Each cycle it may accept one lookup: a 32-bit virtual address, the identifier of the address space that issued it and an access kind (read, write or execute). One cycle later it reports exactly one of three outcomes on registered outputs. A hit carries the physical address. A miss means no matching entry exists. A protection fault means an entry matched but its permission bits forbid the access. Every entry is tagged with its address-space identifier, so translations from several processes can be held together and a lookup only matches an entry of its own address space.

Entries are written through a refill port by whatever walks the page tables. The refill port places the new translation in an entry that already holds the same page and identifier, otherwise in the lowest free entry, otherwise in an entry chosen by a rotating pointer. A flush command empties the whole cache in one cycle, as needed when the active page table changes. The walker, memory access and fault handling sit outside this block.

Top module: `xlat_cache`

## Requirements
- R1: After synchronous active-low reset every entry is empty, the three outcome flags and the physical address are zero, and the first lookup reports a miss.
- R2: The page number is lookup address bits [31:12] and the page offset is bits [11:0]. On a hit the physical address is {frame number, offset}. The outcome appears on the outputs in the cycle after the lookup is presented.
- R3: A lookup hits only on a valid entry whose page number and address-space identifier both equal those of the lookup. An entry with the same page but another identifier gives a miss.
- R4: Entries for the same page under different identifiers coexist, and each lookup returns the frame of its own identifier.
- R5: Access code 0 (read) needs permission bit 0, code 1 (write) needs bit 1, code 2 (execute) needs bit 2, and code 3 is never allowed. A matching entry without the needed bit raises the fault flag with the hit flag low and a zero physical address.
- R6: A lookup with no matching entry raises the miss flag with a zero physical address.
- R7: At most one outcome flag is high at a time, and all outputs are zero in the cycle after a cycle without a lookup.
- R8: A flush empties every entry by the next cycle. A lookup in the same cycle as the flush reports a miss, and a refill in that cycle is discarded.
- R9: A lookup presented in the same cycle as a refill of the same page number (any identifier) reports a miss. The refilled entry is visible to lookups from the following cycle.
- R10: A refill whose page and identifier are already held overwrites that entry. Otherwise it takes the lowest-numbered empty entry, and when all 16 are full it replaces the entry at a rotating pointer that starts at 0 after reset and moves to the next entry (wrapping after 15) after each such replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ins_valid | input | 1 | Refill request this cycle |
| ins_vpn | input | 20 | Page number of the refill |
| ins_asid | input | 8 | Address-space identifier of the refill |
| ins_pfn | input | 20 | Frame number of the refill |
| ins_prot | input | 3 | Permission bits of the refill: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Empty all entries |
| res_hit | output | 1 | Previous lookup translated |
| res_miss | output | 1 | Previous lookup found no entry |
| res_pfault | output | 1 | Previous lookup matched but was not permitted |
| res_paddr | output | 32 | Physical address on a hit, zero otherwise |

## Verification
The assertions take for granted that every input is at a known level whenever a lookup or refill is presented, and that no lookup is presented while reset is held, since the one-cycle look-back checks compare the result with the request of the cycle before. They also rely on the refill rule keeping each page and identifier pair in at most one entry, which no input sequence can break. The stimulus idles all request lines through reset, draws page numbers and identifiers from small pools so that hits, permission faults, same-cycle collisions, overwrites and full-cache replacements all recur, and adds rare flushes.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation cache: access kinds and the
// permission check. Assumes a three-bit permission field (read, write, execute).
package xlat_pkg;

    localparam int PROT_W = 3;
    localparam int PROT_R = 0;
    localparam int PROT_WR = 1;
    localparam int PROT_X = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Returns 1 when the permission bits allow the requested access kind.
    function automatic logic perm_allows(input logic [PROT_W-1:0] prot,
                                         input logic [1:0] acc);
        logic ok;
        case (acc_e'(acc))
            ACC_READ:  ok = prot[PROT_R];
            ACC_WRITE: ok = prot[PROT_WR];
            ACC_EXEC:  ok = prot[PROT_X];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_entry_store.sv
// Entry storage and associative match for the translation cache.
// Holds N entries (valid, identifier, page, frame, permissions), compares
// all of them against the lookup key and against the refill key, and returns
// the lowest matching entry. Assumes the writer never creates two entries
// with the same page and identifier. Flush has priority over a write.
module xlat_entry_store #(
    parameter int N      = 16,
    parameter int ASID_W = 8,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int PROT_W = 3,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic              q_hit,
    output logic [PFN_W-1:0]  q_pfn,
    output logic [PROT_W-1:0] q_prot,
    input  logic [VPN_W-1:0]  p_vpn,
    input  logic [ASID_W-1:0] p_asid,
    output logic              p_hit,
    output logic [IDX_W-1:0]  p_idx,
    output logic [N-1:0]      vld_vec
);

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
    } entry_t;

    logic [PFN_W-1:0]  pfn_a  [N];
    logic [PROT_W-1:0] prot_a [N];
    logic [N-1:0]      q_match;
    logic [N-1:0]      p_match;

    for (genvar i = 0; i < N; i++) begin : g_ent
        entry_t ent_q;

        // Hold one entry: clear on reset or flush, load on a targeted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (flush) begin
                ent_q.vld <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q.vld  <= 1'b1;
                ent_q.asid <= wr_asid;
                ent_q.vpn  <= wr_vpn;
                ent_q.pfn  <= wr_pfn;
                ent_q.prot <= wr_prot;
            end
        end

        assign vld_vec[i] = ent_q.vld;
        assign pfn_a[i]   = ent_q.pfn;
        assign prot_a[i]  = ent_q.prot;
        assign q_match[i] = ent_q.vld && (ent_q.vpn == q_vpn) && (ent_q.asid == q_asid);
        assign p_match[i] = ent_q.vld && (ent_q.vpn == p_vpn) && (ent_q.asid == p_asid);
    end

    // Pick the lowest matching entry for the lookup key.
    always_comb begin
        q_hit  = |q_match;
        q_pfn  = '0;
        q_prot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (q_match[i]) begin
                q_pfn  = pfn_a[i];
                q_prot = prot_a[i];
            end
        end
    end

    // Locate an entry already holding the refill key.
    always_comb begin
        p_hit = |p_match;
        p_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (p_match[i]) p_idx = IDX_W'(i);
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0)) else $error("flush left a valid entry"); // R8
    AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_match)) else $error("two entries matched one key"); // R10

endmodule

// File: rtl/xlat_victim_pick.sv
// Chooses the entry a refill writes: the entry already holding the key,
// else the lowest empty entry, else the one under a rotating pointer.
// The pointer only moves when a refill replaces a live entry of a full store.
module xlat_victim_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vld_vec,
    input  logic             reuse_hit,
    input  logic [IDX_W-1:0] reuse_idx,
    input  logic             take,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    // Find the lowest empty entry.
    always_comb begin
        full     = &vld_vec;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_vec[i]) free_idx = IDX_W'(i);
        end
    end

    // Apply the reuse, free, rotate priority.
    always_comb begin
        if (reuse_hit)  victim_idx = reuse_idx;
        else if (!full) victim_idx = free_idx;
        else            victim_idx = rr_q;
    end

    // Advance the rotating pointer after each replacement in a full store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (take && !reuse_hit && full) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !reuse_hit && !full) |-> !vld_vec[victim_idx])
        else $error("refill overwrote a live entry while space was free"); // R10

endmodule

// File: rtl/xlat_cache.sv
// Top of the translation cache. Splits the lookup address into page and
// offset, queries the entry store, checks permissions and registers one
// outcome per lookup. Refills go to the entry chosen by the victim picker.
// Assumes page offset width OFF_W and equal virtual/physical offset.
module xlat_cache #(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int ASID_W = 8,
    parameter int VPN_W  = VA_W - OFF_W,
    parameter int PFN_W  = PA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic [2:0]        ins_prot,
    input  logic              flush,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_pfault,
    output logic [PA_W-1:0]   res_paddr
);

    localparam int IDX_W  = $clog2(N);
    localparam int PROT_W = xlat_pkg::PROT_W;

    logic [VPN_W-1:0]  lk_vpn;
    logic [OFF_W-1:0]  lk_off;
    logic              collide;
    logic              wr_en;
    logic              q_hit;
    logic [PFN_W-1:0]  q_pfn;
    logic [PROT_W-1:0] q_prot;
    logic              p_hit;
    logic [IDX_W-1:0]  p_idx;
    logic [N-1:0]      vld_vec;
    logic [IDX_W-1:0]  victim_idx;
    logic              allowed;

    // Split the address and flag same-cycle hazards.
    always_comb begin
        lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
        lk_off  = lk_vaddr[OFF_W-1:0];
        collide = ins_valid && (ins_vpn == lk_vpn);
        wr_en   = ins_valid && !flush;
        allowed = xlat_pkg::perm_allows(q_prot, lk_acc);
    end

    xlat_entry_store #(
        .N(N), .ASID_W(ASID_W), .VPN_W(VPN_W), .PFN_W(PFN_W),
        .PROT_W(PROT_W), .IDX_W(IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_idx  (victim_idx),
        .wr_asid (ins_asid),
        .wr_vpn  (ins_vpn),
        .wr_pfn  (ins_pfn),
        .wr_prot (ins_prot),
        .q_vpn   (lk_vpn),
        .q_asid  (lk_asid),
        .q_hit   (q_hit),
        .q_pfn   (q_pfn),
        .q_prot  (q_prot),
        .p_vpn   (ins_vpn),
        .p_asid  (ins_asid),
        .p_hit   (p_hit),
        .p_idx   (p_idx),
        .vld_vec (vld_vec)
    );

    xlat_victim_pick #(.N(N), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_vec    (vld_vec),
        .reuse_hit  (p_hit),
        .reuse_idx  (p_idx),
        .take       (wr_en),
        .victim_idx (victim_idx)
    );

    // Register one outcome per lookup; all zero when no lookup was presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_pfault <= 1'b0;
            res_paddr  <= '0;
        end else begin
            res_hit    <= 1'b0;
            res_miss   <= 1'b0;
            res_pfault <= 1'b0;
            res_paddr  <= '0;
            if (lk_valid) begin
                if (flush || collide || !q_hit) begin
                    res_miss <= 1'b1;
                end else if (allowed) begin
                    res_hit   <= 1'b1;
                    res_paddr <= {q_pfn, lk_off};
                end else begin
                    res_pfault <= 1'b1;
                end
            end
        end
    end

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_miss, res_pfault})) else $error("several outcome flags"); // R7
    AST_FLAG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit || res_miss || res_pfault) |-> $past(lk_valid)) else $error("outcome without lookup"); // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))) else $error("offset changed"); // R2
    AST_NOHIT_NOADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_paddr == '0)) else $error("address without hit"); // R6
    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_valid && flush) |-> res_miss) else $error("lookup during flush did not miss"); // R8
    AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_valid && collide) |-> res_miss) else $error("colliding lookup did not miss"); // R9

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/100ps
module xlat_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_acc = '0;
    logic        ins_valid = 1'b0;
    logic [19:0] ins_vpn = '0;
    logic [7:0]  ins_asid = '0;
    logic [19:0] ins_pfn = '0;
    logic [2:0]  ins_prot = '0;
    logic        flush = 1'b0;
    logic        res_hit;
    logic        res_miss;
    logic        res_pfault;
    logic [31:0] res_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic        m_vld  [16];
    logic [7:0]  m_asid [16];
    logic [19:0] m_vpn  [16];
    logic [19:0] m_pfn  [16];
    logic [2:0]  m_prot [16];
    int          m_rr;

    always #2.5 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_acc(lk_acc), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
        .ins_asid(ins_asid), .ins_pfn(ins_pfn), .ins_prot(ins_prot), .flush(flush),
        .res_hit(res_hit), .res_miss(res_miss), .res_pfault(res_pfault), .res_paddr(res_paddr)
    );

    function automatic logic perm_ok(input logic [2:0] p, input logic [1:0] a);
        if (a == 2'd0) return p[0];
        if (a == 2'd1) return p[1];
        if (a == 2'd2) return p[2];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got hit/miss/fault/paddr=%h expected %h", tag, act, exp);
        end
    endtask

    // Present one cycle of stimulus, predict, update model, check after the edge.
    task automatic op(input logic lv, input logic [31:0] va, input logic [7:0] asid,
                      input logic [1:0] acc, input logic iv, input logic [19:0] ivpn,
                      input logic [7:0] iasid, input logic [19:0] ipfn,
                      input logic [2:0] iprot, input logic fl, input string tag);
        logic e_hit, e_miss, e_pf;
        logic [31:0] e_pa;
        int mi;
        string t;
        lk_valid = lv; lk_vaddr = va; lk_asid = asid; lk_acc = acc;
        ins_valid = iv; ins_vpn = ivpn; ins_asid = iasid; ins_pfn = ipfn;
        ins_prot = iprot; flush = fl;
        e_hit = 0; e_miss = 0; e_pf = 0; e_pa = '0;
        if (lv) begin
            mi = -1;
            for (int i = 15; i >= 0; i--)
                if (m_vld[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) mi = i;
            if (fl || (iv && ivpn == va[31:12]) || mi < 0) e_miss = 1;
            else if (perm_ok(m_prot[mi], acc)) begin
                e_hit = 1; e_pa = {m_pfn[mi], va[11:0]};
            end else e_pf = 1;
        end
        if (fl) begin
            for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
        end else if (iv) begin
            mi = -1;
            for (int i = 15; i >= 0; i--)
                if (m_vld[i] && m_vpn[i] == ivpn && m_asid[i] == iasid) mi = i;
            if (mi < 0)
                for (int i = 15; i >= 0; i--) if (!m_vld[i]) mi = i;
            if (mi < 0) begin
                mi = m_rr;
                m_rr = (m_rr + 1) % 16;
            end
            m_vld[mi] = 1'b1; m_vpn[mi] = ivpn; m_asid[mi] = iasid;
            m_pfn[mi] = ipfn; m_prot[mi] = iprot;
        end
        @(posedge clk); #1;
        t = tag;
        if (t == "") t = !lv ? "R7" : e_hit ? "R2" : e_pf ? "R5" : "R6";
        check(t, {res_hit, res_miss, res_pfault, res_paddr}, {e_hit, e_miss, e_pf, e_pa});
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc,
                        input string tag);
        op(1, va, asid, acc, 0, '0, '0, '0, '0, 0, tag);
    endtask

    task automatic put(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn,
                       input logic [2:0] prot, input string tag);
        op(0, '0, '0, '0, 1, vpn, asid, pfn, prot, 0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 0; m_asid[i] = '0; m_vpn[i] = '0; m_pfn[i] = '0; m_prot[i] = '0;
        end
        m_rr = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: outputs zero after reset, first lookup misses
        check("R1", {res_hit, res_miss, res_pfault, res_paddr}, '0);
        look(32'h1234_5678, 8'd1, 2'd0, "R1");
        // R2: basic translation
        put(20'h12345, 8'd1, 20'hABCDE, 3'b111, "R7");
        look(32'h1234_5678, 8'd1, 2'd0, "R2");
        check("R2", {res_hit, res_paddr}, {1'b1, 32'hABCD_E678});
        // R3: other identifier misses
        look(32'h1234_5678, 8'd2, 2'd0, "R3");
        // R4: two identifiers on one page
        put(20'h12345, 8'd2, 20'h11111, 3'b001, "R7");
        look(32'h1234_5ABC, 8'd2, 2'd0, "R4");
        look(32'h1234_5ABC, 8'd1, 2'd0, "R4");
        // R5: permission faults
        look(32'h1234_5000, 8'd2, 2'd1, "R5");
        look(32'h1234_5000, 8'd2, 2'd2, "R5");
        look(32'h1234_5000, 8'd1, 2'd3, "R5");
        check("R5", {res_pfault, res_hit, res_paddr}, {1'b1, 1'b0, 32'h0});
        // R6: unknown page
        look(32'h0000_1FFF, 8'd1, 2'd0, "R6");
        // R7: idle cycle
        op(0, 32'h1234_5678, 8'd1, 2'd0, 0, '0, '0, '0, '0, 0, "R7");
        // R9: refill colliding with lookup, then visible
        op(1, 32'h0777_7010, 8'd3, 2'd0, 1, 20'h07777, 8'd3, 20'h33333, 3'b111, 0, "R9");
        look(32'h0777_7010, 8'd3, 2'd0, "R9");
        op(1, 32'h1234_5004, 8'd1, 2'd0, 1, 20'h12345, 8'd9, 20'h44444, 3'b111, 0, "R9");
        // R10: overwrite existing key
        put(20'h12345, 8'd1, 20'h22222, 3'b011, "R7");
        look(32'h1234_5004, 8'd1, 2'd1, "R10");
        // R8: flush with lookup and refill
        op(1, 32'h1234_5004, 8'd1, 2'd0, 1, 20'h05555, 8'd1, 20'h55555, 3'b111, 1, "R8");
        look(32'h1234_5004, 8'd2, 2'd0, "R8");
        look(32'h0555_5000, 8'd1, 2'd0, "R8");
        // R10: fill, then rotate
        for (int k = 0; k < 16; k++) put(20'h00100 + 20'(k), 8'd5, 20'h80000 + 20'(k), 3'b111, "R7");
        put(20'h00200, 8'd5, 20'h90000, 3'b111, "R7");
        look(32'h0010_0000, 8'd5, 2'd0, "R10");
        look(32'h0020_0000, 8'd5, 2'd0, "R10");
        look(32'h0010_1000, 8'd5, 2'd0, "R10");
        put(20'h00201, 8'd5, 20'h90001, 3'b111, "R7");
        look(32'h0010_1000, 8'd5, 2'd0, "R10");
        look(32'h0010_2000, 8'd5, 2'd0, "R10");
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic lv, iv, fl;
            logic [31:0] va;
            lv = ($urandom % 4) != 0;
            iv = ($urandom % 3) == 0;
            fl = ($urandom % 64) == 0;
            va = {20'h00300 + 20'($urandom % 12), 12'($urandom)};
            op(lv, va, 8'($urandom % 3 + 1), 2'($urandom), iv,
               20'h00300 + 20'($urandom % 12), 8'($urandom % 3 + 1),
               20'($urandom), 3'($urandom), fl, "");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule